// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block collects eight interrupt request lines and resolves them with fixed priority, where level 0 is the most urgent. It signals the processor on a single interrupt output. Software reaches it through a byte-wide port with two addresses. Address 0 takes commands and returns status. Address 1 holds the mask, and during setup it takes the configuration words. A write to address 0 with bit 4 set starts a setup sequence. The next three writes to address 1 carry, in order, the vector base, the cascade word and the mode word.

An interrupt is taken in one of two ways. The first is a one-cycle acknowledge strobe, during which the vector appears on the vector output. The second is a poll read of the command address. Both move the winning level from the request register into the in-service register. Software retires the level with a non-specific end-of-interrupt command. When a request disappears before it is taken, the block reports level 7 and leaves in-service bit 7 clear, so software can recognise the interrupt as spurious.

Two instances form a master and slave pair. The slave's interrupt output drives one request input of the master. The master asserts `casc_sel` while an acknowledge is granted to a level named in its cascade word. The integrator uses that signal to forward the acknowledge to the slave. The master then passes the slave's vector, taken on `casc_vec`, to its own vector output.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the request and in-service registers are zero, `int_out` is low, and a command-address read returns the request register.
- R2: When no setup is in progress, a write to address 1 loads the mask and a read of address 1 returns it. A 1 in mask bit n blocks level n from `int_out` and from being granted.
- R3: A command write with bit 4 set starts setup. The next three address-1 writes are taken as vector base, cascade word and mode word, in that order, and none of them changes the mask.
- R4: When mode word bit 0 is 1, the vector is {base[7:3], level}. When it is 0, the vector is {base[7:5], level, 2'b00}.
- R5: A rising edge on `irq_in[n]` sets request bit n. A low input clears that bit. An input held high after its request was taken raises no new request.
- R6: `int_out` is high exactly when the lowest-numbered unmasked pending level is numerically below every in-service level.
- R7: When a request is pending, an `inta` pulse sets the winner's in-service bit, clears its request bit and presents its vector on `vec_out` in the same cycle.
- R8: Command 0x0C arms a poll. The next command-address read returns 0x80 | level, acknowledges that level the same way as R7, and disarms the poll.
- R9: Command 0x0B makes command-address reads return the in-service register and 0x0A makes them return the request register. The selection persists across reads.
- R10: Command 0x20 clears the lowest-numbered set bit of the in-service register.
- R11: An acknowledge or poll with no grantable request reports level 7 (vector per R4, poll byte 0x07) and changes neither register.
- R12: In a master (IS_SLAVE=0), an acknowledge granted to a level whose cascade-word bit is set raises `casc_sel` and drives `casc_vec` onto `vec_out`. A slave never raises `casc_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for the poll side effect) |
| bus_addr | input | 1 | 0 = command/status, 1 = mask/setup data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq_in | input | NLVL | Edge-triggered request lines |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | One-cycle acknowledge strobe |
| vec_out | output | 8 | Vector of the granted level, valid with `inta` |
| casc_sel | output | 1 | Acknowledge granted to a cascaded level |
| casc_vec | input | 8 | Vector supplied by the slave |

## Verification
The hardest case to reach is a spurious interrupt. A request has to rise, raise `int_out`, and then fall before any acknowledge, and the acknowledge must still arrive. The bench raises level 7, drops it once `int_out` is seen, and then strobes `inta`. It also issues a poll with nothing pending. In both cases it checks that level 7 is reported and that in-service stays clear. The cascade path is reached through two instances: a slave request has to pass through the slave's edge latch, then through the master's latch on its level 2, before the forwarded acknowledge can be observed.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;
    localparam int DW = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BASE = 2'd1,
        ST_CASC = 2'd2,
        ST_MODE = 2'd3
    } setup_step_e;

    typedef struct packed {
        setup_step_e     step;
        logic [DW-1:0]   mask;
        logic [DW-1:0]   base;
        logic [DW-1:0]   casc;
        logic            mode86;
        logic            sel_isr;
        logic            poll;
    } cfg_t;

    localparam logic [2:0] EOI_NS = 3'b001;
endpackage

// File: rtl/pic_cfg_regs.sv
`timescale 1ns/1ps
module pic_cfg_regs
    import prio_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg_q,
    output logic          eoi
);
    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        eoi   = 1'b0;
        if (wr_en && !addr) begin
            if (wdata[4]) begin
                cfg_d.step = ST_BASE;
            end else if (wdata[3]) begin
                if (wdata[2]) cfg_d.poll = 1'b1;
                if (wdata[1]) cfg_d.sel_isr = wdata[0];
            end else if (wdata[7:5] == EOI_NS) begin
                eoi = 1'b1;
            end
        end else if (wr_en && addr) begin
            case (cfg_q.step)
                ST_BASE: begin cfg_d.base = wdata;      cfg_d.step = ST_CASC; end
                ST_CASC: begin cfg_d.casc = wdata;      cfg_d.step = ST_MODE; end
                ST_MODE: begin cfg_d.mode86 = wdata[0]; cfg_d.step = ST_IDLE; end
                default: cfg_d.mask = wdata;
            endcase
        end
        if (rd_en && !addr) cfg_d.poll = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.step    <= ST_IDLE;
            cfg_q.mask    <= '1;
            cfg_q.base    <= '0;
            cfg_q.casc    <= '0;
            cfg_q.mode86  <= 1'b0;
            cfg_q.sel_isr <= 1'b0;
            cfg_q.poll    <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && cfg_q.step == ST_IDLE) |=> (cfg_q.mask == $past(wdata)));
    a_r3_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && cfg_q.step != ST_IDLE) |=> $stable(cfg_q.mask));
    a_r3_setup_start: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=> (cfg_q.step == ST_BASE));
    a_r8_poll_once: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr && !wr_en) |=> !cfg_q.poll);
endmodule

// File: rtl/pic_req_latch.sv
`timescale 1ns/1ps
module pic_req_latch #(
    parameter int NLVL = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] irq_in,
    input  logic [NLVL-1:0] clr,
    output logic [NLVL-1:0] irr_q
);
    typedef struct packed {
        logic [NLVL-1:0] prev;
        logic [NLVL-1:0] irr;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d.prev = irq_in;
        lat_d.irr  = irq_in & (lat_q.irr | ~lat_q.prev) & ~clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q.prev <= '1;
            lat_q.irr  <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign irr_q = lat_q.irr;

    a_r5_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in == '0) |=> (irr_q == '0));
endmodule

// File: rtl/pic_resolver.sv
`timescale 1ns/1ps
module pic_resolver #(
    parameter int NLVL = 8,
    parameter int LW   = $clog2(NLVL)
) (
    input  logic [NLVL-1:0] irr,
    input  logic [NLVL-1:0] mask,
    input  logic [NLVL-1:0] isr,
    output logic            win_vld,
    output logic [LW-1:0]   win_lvl
);
    logic [NLVL-1:0] pend;
    logic            found, busy;
    logic [LW-1:0]   top_isr;

    always_comb begin
        pend    = irr & ~mask;
        found   = 1'b0;
        busy    = 1'b0;
        win_lvl = '0;
        top_isr = '0;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (pend[i]) begin found = 1'b1; win_lvl = LW'(i); end
            if (isr[i])  begin busy  = 1'b1; top_isr = LW'(i); end
        end
        win_vld = found && (!busy || (win_lvl < top_isr));
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int   NLVL     = 8,
    parameter bit   IS_SLAVE = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic            bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NLVL-1:0] irq_in,
    output logic            int_out,
    input  logic            inta,
    output logic [DW-1:0]   vec_out,
    output logic            casc_sel,
    input  logic [DW-1:0]   casc_vec
);
    localparam int LW = $clog2(NLVL);

    typedef struct packed {
        logic [NLVL-1:0] isr;
    } svc_t;

    cfg_t            cfg;
    logic            eoi;
    logic [NLVL-1:0] irr, clr;
    logic            win_vld;
    logic [LW-1:0]   win_lvl, lvl_out;
    logic            take, grant, cleared;
    logic [DW-1:0]   own_vec;
    svc_t            svc_d, svc_q;

    pic_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata), .cfg_q(cfg), .eoi(eoi)
    );

    pic_req_latch #(.NLVL(NLVL)) u_lat (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr(clr), .irr_q(irr)
    );

    pic_resolver #(.NLVL(NLVL), .LW(LW)) u_res (
        .irr(irr), .mask(cfg.mask[NLVL-1:0]), .isr(svc_q.isr),
        .win_vld(win_vld), .win_lvl(win_lvl)
    );

    always_comb begin
        take    = inta || (bus_rd && !bus_addr && cfg.poll);
        grant   = take && win_vld;
        svc_d   = svc_q;
        clr     = '0;
        cleared = 1'b0;
        if (eoi) begin
            for (int i = 0; i < NLVL; i++) begin
                if (!cleared && svc_q.isr[i]) begin
                    svc_d.isr[i] = 1'b0;
                    cleared      = 1'b1;
                end
            end
        end
        if (grant) begin
            svc_d.isr[win_lvl] = 1'b1;
            clr[win_lvl]       = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= svc_d;
    end

    assign lvl_out  = win_vld ? win_lvl : '1;
    assign own_vec  = cfg.mode86 ? {cfg.base[DW-1:LW], lvl_out}
                                 : {cfg.base[DW-1:LW+2], lvl_out, 2'b00};
    assign casc_sel = !IS_SLAVE && inta && win_vld && cfg.casc[win_lvl];
    assign vec_out  = casc_sel ? casc_vec : own_vec;
    assign int_out  = win_vld;

    always_comb begin
        if (bus_addr)         bus_rdata = cfg.mask;
        else if (cfg.poll)    bus_rdata = {win_vld, {(DW-1-LW){1'b0}}, lvl_out};
        else if (cfg.sel_isr) bus_rdata = DW'(svc_q.isr);
        else                  bus_rdata = DW'(irr);
    end

    a_r6_level0_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        svc_q.isr[0] |-> !int_out);
    a_r7_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && int_out && !bus_wr) |=> ($countones(svc_q.isr) == $countones($past(svc_q.isr)) + 1));
    a_r10_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && svc_q.isr != '0 && !take) |=> ($countones(svc_q.isr) == $countones($past(svc_q.isr)) - 1));
    a_r11_spurious_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !int_out && !bus_wr) |=> $stable(svc_q.isr));
    a_r12_casc_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        casc_sel |-> int_out);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       wr = 0, rd = 0, addr = 0, inta = 0;
    logic       s_wr = 0, s_rd = 0, s_addr = 0;
    logic [7:0] wdata = 0, b_irq = 0, s_irq = 0;
    wire  [7:0] m_rdata, s_rdata, m_vec, s_vec;
    wire        m_int, s_int, m_csel, s_csel;
    wire  [7:0] m_irq  = {b_irq[7:3], s_int, b_irq[1:0]};
    wire        s_inta = inta & m_csel;

    int checks = 0, errs = 0;
    bit finished = 0;

    prio_irq_ctrl #(.NLVL(8), .IS_SLAVE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(m_rdata), .irq_in(m_irq), .int_out(m_int),
        .inta(inta), .vec_out(m_vec), .casc_sel(m_csel), .casc_vec(s_vec)
    );

    prio_irq_ctrl #(.NLVL(8), .IS_SLAVE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_wr(s_wr), .bus_rd(s_rd), .bus_addr(s_addr),
        .bus_wdata(wdata), .bus_rdata(s_rdata), .irq_in(s_irq), .int_out(s_int),
        .inta(s_inta), .vec_out(s_vec), .casc_sel(s_csel), .casc_vec(8'h00)
    );

    // behavioural model of the master's request/service/mask state
    logic [7:0] md_irr, md_isr, md_mask, md_prev;
    int         md_step;
    bit         md_poll;

    function automatic int md_win();
        for (int l = 0; l < 8; l++) begin
            if (md_isr[l]) return -1;
            if (md_irr[l] && !md_mask[l]) return l;
        end
        return -1;
    endfunction

    always @(posedge clk) begin : mdl
        int  w;
        bit  tk, gone;
        if (!rst_n) begin
            md_irr = 0; md_isr = 0; md_mask = 8'hFF; md_prev = 8'hFF;
            md_step = 0; md_poll = 0;
        end else begin
            w  = md_win();
            tk = inta || (rd && !addr && md_poll);
            for (int l = 0; l < 8; l++) begin
                if (!m_irq[l]) md_irr[l] = 1'b0;
                else if (!md_prev[l]) md_irr[l] = 1'b1;
            end
            md_prev = m_irq;
            if (wr && !addr && !wdata[4] && !wdata[3] && wdata[7:5] == 3'b001) begin
                gone = 0;
                for (int l = 0; l < 8; l++)
                    if (!gone && md_isr[l]) begin md_isr[l] = 1'b0; gone = 1; end
            end
            if (tk && w >= 0) begin md_isr[w] = 1'b1; md_irr[w] = 1'b0; end
            if (wr && !addr) begin
                if (wdata[4]) md_step = 1;
                else if (wdata[3] && wdata[2]) md_poll = 1;
            end else if (wr && addr) begin
                if (md_step == 0) md_mask = wdata;
                else md_step = (md_step + 1) % 4;
            end
            if (rd && !addr) md_poll = 0;
        end
    end

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // R6: interrupt output compared with the model every clock
    always @(negedge clk) begin
        if (rst_n && !finished) check8({7'd0, m_int}, {7'd0, md_win() >= 0}, "R6 model int_out");
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic mwr(input logic a, input logic [7:0] d);
        @(negedge clk); wr = 1; addr = a; wdata = d;
        @(negedge clk); wr = 0;
    endtask
    task automatic swr(input logic a, input logic [7:0] d);
        @(negedge clk); s_wr = 1; s_addr = a; wdata = d;
        @(negedge clk); s_wr = 0;
    endtask
    task automatic mrd(input logic a, input logic [7:0] exp, input string tag);
        @(negedge clk); rd = 1; addr = a; #1;
        check8(m_rdata, exp, tag);
        @(negedge clk); rd = 0;
    endtask
    task automatic srd(input logic a, input logic [7:0] exp, input string tag);
        @(negedge clk); s_rd = 1; s_addr = a; #1;
        check8(s_rdata, exp, tag);
        @(negedge clk); s_rd = 0;
    endtask
    task automatic ack(input logic [7:0] exp, input logic csel, input string tag);
        @(negedge clk); inta = 1; #1;
        check8(m_vec, exp, tag);
        check8({7'd0, m_csel}, {7'd0, csel}, tag);
        @(negedge clk); inta = 0;
    endtask
    task automatic irq(input logic [7:0] v);
        @(negedge clk); b_irq = v;
        @(negedge clk);
    endtask
    task automatic chk_int(input logic exp, input string tag);
        #1 check8({7'd0, m_int}, {7'd0, exp}, tag);
    endtask
    task automatic summary();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errs++;
        $display("FAIL R1 watchdog act=hung exp=done");
        summary();
    end

    initial begin
        tick(3); rst_n = 1; tick(1);
        chk_int(0, "R1 int_out after reset");
        mrd(1, 8'hFF, "R1 mask after reset");
        mrd(0, 8'h00, "R1 irr after reset");

        mwr(1, 8'h5A); mrd(1, 8'h5A, "R2 mask readback");

        mwr(0, 8'h11); mwr(1, 8'h00); mwr(1, 8'h04); mwr(1, 8'h01);
        mrd(1, 8'h5A, "R3 setup leaves mask");
        mwr(1, 8'h00); mrd(1, 8'h00, "R2 mask load after setup");
        swr(0, 8'h11); swr(1, 8'h08); swr(1, 8'h02); swr(1, 8'h01); swr(1, 8'h00);

        irq(8'h20); chk_int(1, "R5 edge raises int");
        mrd(0, 8'h20, "R5 irr bit set");
        ack(8'h05, 0, "R7 vector level 5");
        mwr(0, 8'h0B);
        mrd(0, 8'h20, "R9 isr selected");
        mrd(0, 8'h20, "R9 selection persists");
        mwr(0, 8'h20); tick(1);
        chk_int(0, "R5 held input no retrigger");
        mwr(0, 8'h0A); mrd(0, 8'h00, "R5 irr clear after ack");
        irq(8'h00);

        irq(8'h48); chk_int(1, "R6 pending pair");
        ack(8'h03, 0, "R6 level 3 wins over 6");
        chk_int(0, "R6 lower blocked by service");
        irq(8'h4A); chk_int(1, "R6 higher preempts");
        ack(8'h01, 0, "R7 vector level 1");
        mwr(0, 8'h0B); mrd(0, 8'h0A, "R7 isr bits 1 and 3");
        mwr(0, 8'h20); mrd(0, 8'h08, "R10 lowest cleared");
        mwr(0, 8'h20); mrd(0, 8'h00, "R10 second eoi");
        chk_int(1, "R6 level 6 released");
        ack(8'h06, 0, "R7 vector level 6");
        mwr(0, 8'h20); irq(8'h00);

        mwr(1, 8'h10); irq(8'h10); chk_int(0, "R2 masked level");
        mwr(1, 8'h00); chk_int(1, "R2 unmasked level");
        mwr(0, 8'h0C);
        mrd(0, 8'h84, "R8 poll byte");
        mrd(0, 8'h10, "R8 poll disarmed isr shown");
        chk_int(0, "R8 poll acknowledged");
        mwr(0, 8'h20); irq(8'h00);

        irq(8'h80); chk_int(1, "R11 level 7 raised");
        irq(8'h00); chk_int(0, "R11 request withdrawn");
        ack(8'h07, 0, "R11 spurious vector");
        mrd(0, 8'h00, "R11 isr bit 7 clear");
        mwr(0, 8'h0C); mrd(0, 8'h07, "R11 empty poll");

        mwr(0, 8'h11); mwr(1, 8'h40); mwr(1, 8'h04); mwr(1, 8'h00);
        irq(8'h08); ack(8'h4C, 0, "R4 spaced vector");
        mwr(0, 8'h20); irq(8'h00);
        mwr(0, 8'h11); mwr(1, 8'h00); mwr(1, 8'h04); mwr(1, 8'h01);

        @(negedge clk); s_irq = 8'h10; tick(2);
        chk_int(1, "R12 slave raises master");
        ack(8'h0C, 1, "R12 cascaded vector");
        mrd(0, 8'h04, "R12 master isr level 2");
        swr(0, 8'h0B); srd(0, 8'h10, "R12 slave isr level 4");
        swr(0, 8'h20); mwr(0, 8'h20);
        mrd(0, 8'h00, "R10 master isr retired");
        @(negedge clk); s_irq = 8'h00; tick(3);

        summary();
    end
endmodule